// File: doc/BRIEF.md
# Multi-Lane Receive Deskew Supervisor

This block supervises lane alignment on the receive side of a bonded serial link made of many lanes, 24 by default. Each lane feeds an elastic FIFO. Every FIFO reports two watermark flags: almost-empty and almost-full. The supervisor stays idle until the link reports ready and every lane reports both block lock and frame lock. From then on it watches the race between the FIFO flags. If any FIFO reaches almost-full while another FIFO is still almost-empty, the lanes are skewed beyond what the FIFOs can absorb. In that case the block sends a one-cycle realign pulse to all FIFOs, waits a fixed settle time and then judges the race again. If the watermark flags all clear, the lanes are aligned. The block then raises read enable on every lane in the same cycle and keeps it raised.

A loss of lock on any lane, or a drop of link-ready, stops the reads and sends the block back to waiting for lock. A saturating counter reports how many realign pulses have been issued. The FIFOs, the PCS and the 64-bit data and 10-bit control lane buses lie outside this block.

Top module: `lane_deskew_ctrl`

## Requirements
- R1: A synchronous active-high reset drives realign pulse, read enable, done flag and realign count to zero, and puts the block in the wait-for-lock state.
- R2: The FIFO flags are ignored until link-ready is high and every bit of the block-lock and frame-lock vectors is one. Only the edge where this condition is first seen starts monitoring; no pulse and no done result from that edge.
- R3: While monitoring, if any almost-full bit is high and any almost-empty bit is high at a clock edge, the realign output is high for exactly the one following cycle.
- R4: After a realign pulse the flags are ignored for SETTLE (default 8) clock edges. The race is judged again at the edge that follows them, so the earliest next pulse comes 9 cycles after the previous one.
- R5: While monitoring, if every almost-full bit and every almost-empty bit is low at a clock edge, then from the next cycle all bits of the read-enable vector and the done flag are high together, and they stay high while lock holds.
- R6: While monitoring, some almost-empty bits high with all almost-full bits low, or some almost-full bits high with all almost-empty bits low, produce neither a pulse nor done.
- R7: At an edge where link-ready is low or any block-lock or frame-lock bit is low, the block returns to waiting. From the next cycle read enable and done are zero. The lock loss takes priority over a failed race seen at the same edge, so no pulse is issued.
- R8: The 8-bit realign count rises by one with each realign pulse and saturates at 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive-side clock |
| rst | input | 1 | Synchronous active-high reset |
| linkReady | input | 1 | Receive path ready indication |
| blockLock | input | LANES | Per-lane block lock |
| frameLock | input | LANES | Per-lane frame lock |
| fifoAlmostEmpty | input | LANES | Per-lane FIFO almost-empty flag |
| fifoAlmostFull | input | LANES | Per-lane FIFO almost-full flag |
| realignClr | output | 1 | One-cycle pulse asking all FIFOs to realign |
| readEn | output | LANES | Per-lane FIFO read enable, all-or-none |
| deskewDone | output | 1 | Lanes aligned and reading |
| realignCount | output | CNT_W | Saturating count of realign pulses |

## Verification
A lock loss and a failed flag race can arrive at the same clock edge. The bench provokes this by dropping link-ready while presenting a failing flag pattern to a monitoring block. The expected result is no realign pulse, an unchanged realign count, and a return to waiting that shows as a later done only after a fresh lock and a clean flag set. The same collision is exercised with a single lane's frame lock dropping while the block is already aligned.

// File: rtl/lane_deskew_pkg.sv
package lane_deskew_pkg;

  typedef enum logic [1:0] {
    ST_WAIT_LOCK,
    ST_MONITOR,
    ST_SETTLE,
    ST_ALIGNED
  } deskewState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic fireRealign;
    logic loadSettle;
    logic decSettle;
    logic aligned;
  } ctrlStrobe_t;

endpackage

// File: rtl/deskew_datapath.sv
module deskew_datapath
  import lane_deskew_pkg::*;
#(
  parameter int LANES  = 24,
  parameter int SETTLE = 8,
  parameter int CNT_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               linkReady,
  input  logic [LANES-1:0]   blockLock,
  input  logic [LANES-1:0]   frameLock,
  input  logic [LANES-1:0]   fifoAlmostEmpty,
  input  logic [LANES-1:0]   fifoAlmostFull,
  input  ctrlStrobe_t        strobe,
  output logic               lockOk,
  output logic               raceFail,
  output logic               raceWon,
  output logic               settleDone,
  output logic               realignClr,
  output logic [LANES-1:0]   readEn,
  output logic               deskewDone,
  output logic [CNT_W-1:0]   realignCount
);

  localparam int SET_W = (SETTLE > 1) ? $clog2(SETTLE) : 1;
  localparam logic [SET_W-1:0] SETTLE_LOAD = SET_W'(SETTLE - 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [SET_W-1:0] settleCnt;

  // flag reductions
  always_comb begin
    lockOk   = linkReady && (&blockLock) && (&frameLock);
    raceFail = (|fifoAlmostFull) && (|fifoAlmostEmpty);
    raceWon  = !(|fifoAlmostFull) && !(|fifoAlmostEmpty);
    settleDone = (settleCnt == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      settleCnt <= '0;
    end else if (strobe.loadSettle) begin
      settleCnt <= SETTLE_LOAD;
    end else if (strobe.decSettle && !settleDone) begin
      settleCnt <= settleCnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      realignClr   <= 1'b0;
      readEn       <= '0;
      deskewDone   <= 1'b0;
      realignCount <= '0;
    end else begin
      realignClr <= strobe.fireRealign;
      readEn     <= {LANES{strobe.aligned}};
      deskewDone <= strobe.aligned;
      if (strobe.fireRealign && (realignCount != CNT_MAX))
        realignCount <= realignCount + 1'b1;
    end
  end

endmodule

// File: rtl/deskew_control.sv
module deskew_control
  import lane_deskew_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        lockOk,
  input  logic        raceFail,
  input  logic        raceWon,
  input  logic        settleDone,
  output ctrlStrobe_t strobe
);

  deskewState_t state, nextState;

  always_comb begin
    nextState = state;
    strobe    = '0;
    case (state)
      ST_WAIT_LOCK: if (lockOk) nextState = ST_MONITOR;
      ST_MONITOR: begin
        if (!lockOk) nextState = ST_WAIT_LOCK;
        else if (raceFail) begin
          nextState          = ST_SETTLE;
          strobe.fireRealign = 1'b1;
          strobe.loadSettle  = 1'b1;
        end else if (raceWon) nextState = ST_ALIGNED;
      end
      ST_SETTLE: begin
        if (!lockOk) nextState = ST_WAIT_LOCK;
        else if (settleDone) nextState = ST_MONITOR;
        else strobe.decSettle = 1'b1;
      end
      ST_ALIGNED: if (!lockOk) nextState = ST_WAIT_LOCK;
      default: nextState = ST_WAIT_LOCK;
    endcase
    strobe.aligned = (nextState == ST_ALIGNED);
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_WAIT_LOCK;
    else     state <= nextState;
  end

endmodule

// File: rtl/lane_deskew_ctrl.sv
module lane_deskew_ctrl
  import lane_deskew_pkg::*;
#(
  parameter int LANES  = 24,
  parameter int SETTLE = 8,
  parameter int CNT_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             linkReady,
  input  logic [LANES-1:0] blockLock,
  input  logic [LANES-1:0] frameLock,
  input  logic [LANES-1:0] fifoAlmostEmpty,
  input  logic [LANES-1:0] fifoAlmostFull,
  output logic             realignClr,
  output logic [LANES-1:0] readEn,
  output logic             deskewDone,
  output logic [CNT_W-1:0] realignCount
);

  ctrlStrobe_t strobe;
  logic lockOk, raceFail, raceWon, settleDone;

  deskew_control u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .lockOk     (lockOk),
    .raceFail   (raceFail),
    .raceWon    (raceWon),
    .settleDone (settleDone),
    .strobe     (strobe)
  );

  deskew_datapath #(.LANES(LANES), .SETTLE(SETTLE), .CNT_W(CNT_W)) u_dp (
    .clk             (clk),
    .rst             (rst),
    .linkReady       (linkReady),
    .blockLock       (blockLock),
    .frameLock       (frameLock),
    .fifoAlmostEmpty (fifoAlmostEmpty),
    .fifoAlmostFull  (fifoAlmostFull),
    .strobe          (strobe),
    .lockOk          (lockOk),
    .raceFail        (raceFail),
    .raceWon         (raceWon),
    .settleDone      (settleDone),
    .realignClr      (realignClr),
    .readEn          (readEn),
    .deskewDone      (deskewDone),
    .realignCount    (realignCount)
  );

endmodule

// File: rtl/lane_deskew_ctrl_chk.sv
module lane_deskew_ctrl_chk #(
  parameter int LANES  = 24,
  parameter int SETTLE = 8,
  parameter int CNT_W  = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             linkReady,
  input logic [LANES-1:0] blockLock,
  input logic [LANES-1:0] frameLock,
  input logic [LANES-1:0] fifoAlmostEmpty,
  input logic [LANES-1:0] fifoAlmostFull,
  input logic             realignClr,
  input logic [LANES-1:0] readEn,
  input logic             deskewDone,
  input logic [CNT_W-1:0] realignCount
);

  logic portLock;
  logic [15:0] sinceClr;

  assign portLock = linkReady && (&blockLock) && (&frameLock);

  // cycles since last pulse, held at maximum across lock loss
  always_ff @(posedge clk) begin
    if (rst || !portLock) sinceClr <= '1;
    else if (realignClr)  sinceClr <= 16'd1;
    else if (sinceClr != '1) sinceClr <= sinceClr + 1'b1;
  end

  assert_pulse_width_R3: assert property (@(posedge clk) disable iff (rst)
    realignClr |=> !realignClr);

  assert_pulse_cause_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(realignClr) |-> $past(portLock && (|fifoAlmostFull) && (|fifoAlmostEmpty)));

  assert_settle_gap_R4: assert property (@(posedge clk) disable iff (rst)
    realignClr |-> (sinceClr > 16'(SETTLE)));

  assert_done_cause_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(deskewDone) |-> $past(portLock && !(|fifoAlmostFull) && !(|fifoAlmostEmpty)));

  assert_all_lanes_R5: assert property (@(posedge clk) disable iff (rst)
    deskewDone |-> (&readEn));

  assert_no_read_idle_R5: assert property (@(posedge clk) disable iff (rst)
    !deskewDone |-> (readEn == '0));

  assert_lock_drop_R7: assert property (@(posedge clk) disable iff (rst)
    !portLock |=> (!deskewDone && !realignClr));

  assert_count_step_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(realignClr) |-> ((realignCount == CNT_W'($past(realignCount) + 1'b1)) || (&$past(realignCount))));

  assert_count_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !realignClr |-> $stable(realignCount));

endmodule

bind lane_deskew_ctrl lane_deskew_ctrl_chk #(.LANES(LANES), .SETTLE(SETTLE), .CNT_W(CNT_W)) u_chk (
  .clk             (clk),
  .rst             (rst),
  .linkReady       (linkReady),
  .blockLock       (blockLock),
  .frameLock       (frameLock),
  .fifoAlmostEmpty (fifoAlmostEmpty),
  .fifoAlmostFull  (fifoAlmostFull),
  .realignClr      (realignClr),
  .readEn          (readEn),
  .deskewDone      (deskewDone),
  .realignCount    (realignCount)
);

// File: tb/lane_deskew_ctrl_test.sv
`timescale 1ns/1ps
module lane_deskew_ctrl_test;

  localparam int LANES = 24;
  localparam int SETTLE = 8;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic linkReady = 1'b0;
  logic [LANES-1:0] blockLock = '0, frameLock = '0;
  logic [LANES-1:0] fifoAlmostEmpty = '0, fifoAlmostFull = '0;
  logic realignClr, deskewDone;
  logic [LANES-1:0] readEn;
  logic [CNT_W-1:0] realignCount;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  lane_deskew_ctrl #(.LANES(LANES), .SETTLE(SETTLE), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst), .linkReady(linkReady), .blockLock(blockLock),
    .frameLock(frameLock), .fifoAlmostEmpty(fifoAlmostEmpty),
    .fifoAlmostFull(fifoAlmostFull), .realignClr(realignClr), .readEn(readEn),
    .deskewDone(deskewDone), .realignCount(realignCount)
  );

  typedef struct packed {
    logic       rdy;
    logic       lk;
    logic [23:0] pe;
    logic [23:0] pf;
    logic       expClr;
    logic       expDone;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b1, 24'h000001, 24'hfffffe, 1'b0, 1'b0}, // R2 fail flags, not ready
    '{1'b1, 1'b1, 24'hffffff, 24'h000000, 1'b0, 1'b0}, // R2 lock seen, start
    '{1'b1, 1'b1, 24'h000001, 24'hfffffe, 1'b1, 1'b0}, // R3 race lost
    '{1'b1, 1'b1, 24'h000000, 24'h000000, 1'b0, 1'b0}, // R4 settle, clean ignored
    '{1'b1, 1'b1, 24'h000001, 24'hfffffe, 1'b0, 1'b0}, // R4 settle, fail ignored
    '{1'b1, 1'b1, 24'h000001, 24'hfffffe, 1'b0, 1'b0},
    '{1'b1, 1'b1, 24'h000001, 24'hfffffe, 1'b0, 1'b0},
    '{1'b1, 1'b1, 24'h000001, 24'hfffffe, 1'b0, 1'b0},
    '{1'b1, 1'b1, 24'h000001, 24'hfffffe, 1'b0, 1'b0},
    '{1'b1, 1'b1, 24'h000001, 24'hfffffe, 1'b0, 1'b0},
    '{1'b1, 1'b1, 24'h000000, 24'h000000, 1'b0, 1'b0}, // R4 last settle edge
    '{1'b1, 1'b1, 24'h000000, 24'h000000, 1'b0, 1'b1}, // R5 race won
    '{1'b1, 1'b1, 24'h000001, 24'hfffffe, 1'b0, 1'b1}, // R5 held while locked
    '{1'b1, 1'b0, 24'h000000, 24'h000000, 1'b0, 1'b0}  // R7 lock lost
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic drive(input logic rdy, input logic [LANES-1:0] lk,
                       input logic [LANES-1:0] pe, input logic [LANES-1:0] pf);
    linkReady = rdy; blockLock = lk; frameLock = lk;
    fifoAlmostEmpty = pe; fifoAlmostFull = pf;
  endtask

  task automatic doReset();
    rst = 1'b1;
    drive(1'b0, '0, '0, '0);
    step(); step();
    rst = 1'b0;
  endtask

  initial begin
    #(5.0 * 200000);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    doReset();
    // R1 reset state
    check("R1 clr", realignClr, 0);
    check("R1 readEn", readEn, 0);
    check("R1 done", deskewDone, 0);
    check("R1 count", realignCount, 0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].rdy, {LANES{VEC[i].lk}}, VEC[i].pe, VEC[i].pf);
      step();
      check($sformatf("R3/R4/R5 row%0d clr", i), realignClr, VEC[i].expClr);
      check($sformatf("R5/R7 row%0d done", i), deskewDone, VEC[i].expDone);
      check($sformatf("R5/R7 row%0d readEn", i), readEn, {LANES{VEC[i].expDone}});
    end
    check("R8 count after one realign", realignCount, 1);

    // R6: partial flags, neither result
    drive(1'b1, '1, 24'hffffff, '0); step();   // to monitor
    drive(1'b1, '1, 24'h800000, '0); step();
    check("R6 empty only clr", realignClr, 0);
    check("R6 empty only done", deskewDone, 0);
    drive(1'b1, '1, '0, 24'h000010); step();
    check("R6 full only clr", realignClr, 0);
    check("R6 full only done", deskewDone, 0);
    drive(1'b1, '1, '0, '0); step();
    check("R5 after partial flags", deskewDone, 1);

    // R7: single lane frame lock drop while aligned
    drive(1'b1, '1, '0, '0); frameLock = 24'hfffffe; step();
    check("R7 one lane lock drop done", deskewDone, 0);
    check("R7 one lane lock drop readEn", readEn, 0);

    // R7: lock loss at the same edge as a failed race
    drive(1'b1, '1, 24'hffffff, '0); step();   // to monitor
    drive(1'b0, '1, 24'h000001, 24'hfffffe); step();
    check("R7 collision no pulse", realignClr, 0);
    check("R7 collision count", realignCount, 1);
    drive(1'b1, '1, 24'h000001, 24'hfffffe); step(); // relock, start monitoring
    check("R2 relock no pulse", realignClr, 0);

    // R8: saturation
    for (int n = 0; n < 260; n++) begin
      drive(1'b1, '1, 24'h000001, 24'hfffffe);
      repeat (SETTLE + 1) step();
    end
    check("R8 saturation", realignCount, 255);

    // R1: reset while aligned
    drive(1'b1, '1, '0, '0);
    repeat (SETTLE + 2) step();
    check("R5 aligned before reset", deskewDone, 1);
    rst = 1'b1; step(); rst = 1'b0;
    check("R1 mid reset done", deskewDone, 0);
    check("R1 mid reset count", realignCount, 0);
    check("R1 mid reset readEn", readEn, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule